// File: doc/BRIEF.md
# Bit-Serial Adder with Registered Carry

This block adds two unsigned operands one bit position per clock. It reuses a single full-adder cell for every position. A start strobe loads both operands in parallel into right-shifting registers and clears a dedicated carry flip-flop. On each working cycle the full adder combines three bits: the lowest bit of each operand register and the stored carry. The adder's carry-out goes back into the flip-flop for the next position. Its sum bit enters the top of a result shift register, so the least significant sum bit ends up at bit 0 once every position has been processed.

A counter of clog2(W) bits tracks the positions. After exactly W working cycles the block drops its busy flag. It then raises a one-cycle completion pulse and presents the W-bit sum and the final carry. While no addition is running, every register holds its value. A start that arrives during an addition is ignored. A start in the completion cycle begins the next addition at once. With the default W of 8, one addition takes eight cycles and the result is valid on the cycle the completion pulse rises.

Top module: `bsa_serial_adder`

## Requirements
- R1: After synchronous reset, sum_out is 0, carry_out is 0, busy is 0 and done is 0.
- R2: A start seen at a clock edge while busy is 0 loads opnd_x and opnd_y. At that same edge it clears the carry flip-flop, so one cycle later busy is 1, carry_out is 0 and done is 0.
- R3: busy stays 1 for exactly W clock cycles after an accepted start. It then falls, and done is 1 for exactly one cycle, in the first cycle with busy at 0.
- R4: In the cycle done is 1, sum_out equals (opnd_x + opnd_y) mod 2^W for the operands loaded at the accepted start, and carry_out equals bit W of that sum.
- R5: A carry of 1 left by a previous addition does not reach the next one, because an accepted start clears it.
- R6: A start that arrives while busy is 1 is ignored. The running addition keeps its operands, its result and its completion cycle.
- R7: While busy is 0 and no start is accepted, sum_out and carry_out hold their values.
- R8: A start in the cycle done is 1 is accepted and begins a new addition on the next cycle.
- R9: Operand bits are consumed least significant first, and each sum bit enters sum_out at bit W-1. After the first working cycle, sum_out[W-1] equals opnd_x[0] XOR opnd_y[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe that begins an addition when idle |
| opnd_x | input | W | First operand, captured at an accepted start |
| opnd_y | input | W | Second operand, captured at an accepted start |
| sum_out | output | W | Result shift register contents |
| carry_out | output | 1 | Carry flip-flop contents; final carry after completion |
| busy | output | 1 | High while working cycles are in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse and the acceptance of a new start can share one cycle. The bench provokes this by raising start in the very cycle done is high, several times in a row. It judges the result by checking three things: the first result at that pulse, busy rising on the next cycle with a cleared carry, and the second sum appearing exactly W cycles later. A start raised in the middle of a run, including with operands that would change the answer, must leave both the result and the completion cycle of the running addition untouched.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    // Result of one full-adder evaluation
    typedef struct packed {
        logic sum;
        logic carry;
    } fa_out_t;

    // Sequencer phase
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;

    // Width of a position counter for a given operand width
    function automatic int unsigned cnt_width(input int unsigned w);
        return (w < 2) ? 1 : $clog2(w);
    endfunction

endpackage

// File: rtl/bsa_full_adder.sv
module bsa_full_adder
    import bsa_pkg::*;
(
    input  logic    bit_a,
    input  logic    bit_b,
    input  logic    bit_c,
    output fa_out_t res
);
    logic half;

    always_comb begin
        half      = bit_a ^ bit_b;
        res.sum   = half ^ bit_c;
        res.carry = (bit_a & bit_b) | (half & bit_c);
    end
endmodule

// File: rtl/bsa_carry_ff.sv
module bsa_carry_ff (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= 1'b0;
        end else if (en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/bsa_shreg.sv
module bsa_shreg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic upper;
        if (i == W - 1) begin : g_top
            assign upper = ser_in;
        end else begin : g_mid
            assign upper = q[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else if (load) begin
                q[i] <= par_in[i];
            end else if (shift) begin
                q[i] <= upper;
            end
        end
    end
endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
    import bsa_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic shift,
    output logic carry_clr,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = cnt_width(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    phase_t        phase;
    logic [CW-1:0] pos;
    logic          last_pos;

    always_comb begin
        load      = (phase == PH_IDLE) && start;
        shift     = (phase == PH_RUN);
        carry_clr = load;
        busy      = (phase == PH_RUN);
        last_pos  = (pos == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            pos   <= '0;
            done  <= 1'b0;
        end else begin
            done <= shift && last_pos;
            if (load) begin
                phase <= PH_RUN;
                pos   <= '0;
            end else if (shift) begin
                if (last_pos) begin
                    phase <= PH_IDLE;
                    pos   <= '0;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bsa_serial_adder.sv
module bsa_serial_adder
    import bsa_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] opnd_x,
    input  logic [W-1:0] opnd_y,
    output logic [W-1:0] sum_out,
    output logic         carry_out,
    output logic         busy,
    output logic         done
);
    logic         load, shift, carry_clr;
    logic [W-1:0] xq, yq;
    fa_out_t      fa;

    bsa_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .load(load), .shift(shift), .carry_clr(carry_clr),
        .busy(busy), .done(done)
    );

    bsa_shreg #(.W(W)) u_xreg (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .ser_in(1'b0), .par_in(opnd_x), .q(xq)
    );

    bsa_shreg #(.W(W)) u_yreg (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .ser_in(1'b0), .par_in(opnd_y), .q(yq)
    );

    bsa_full_adder u_fa (
        .bit_a(xq[0]), .bit_b(yq[0]), .bit_c(carry_out), .res(fa)
    );

    bsa_carry_ff u_cff (
        .clk(clk), .rst(rst), .clr(carry_clr), .en(shift),
        .d(fa.carry), .q(carry_out)
    );

    bsa_shreg #(.W(W)) u_zreg (
        .clk(clk), .rst(rst), .load(1'b0), .shift(shift),
        .ser_in(fa.sum), .par_in('0), .q(sum_out)
    );
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] opnd_x,
    input logic [W-1:0] opnd_y,
    input logic [W-1:0] sum_out,
    input logic         carry_out,
    input logic         busy,
    input logic         done
);
    localparam int unsigned BW = $clog2(W + 1) + 1;

    logic [BW-1:0] run_len;
    logic [W:0]    want;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            want    <= '0;
        end else begin
            run_len <= busy ? run_len + 1'b1 : '0;
            if (start && !busy) begin
                want <= {1'b0, opnd_x} + {1'b0, opnd_y};
            end
        end
    end

    p_load_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !carry_out && !done));

    p_run_length_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == BW'(W)));

    p_run_bound_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < BW'(W)));

    p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_result_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> ({carry_out, sum_out} == want));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(sum_out) && $stable(carry_out)));
endmodule

bind bsa_serial_adder bsa_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .opnd_x(opnd_x), .opnd_y(opnd_y),
    .sum_out(sum_out), .carry_out(carry_out), .busy(busy), .done(done)
);

// File: tb/tb_bsa_serial_adder.sv
module tb_bsa_serial_adder;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] opnd_x, opnd_y;
    logic [W-1:0] sum_out;
    logic         carry_out, busy, done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    bsa_serial_adder #(.W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .opnd_x(opnd_x), .opnd_y(opnd_y),
        .sum_out(sum_out), .carry_out(carry_out), .busy(busy), .done(done)
    );

    function automatic logic [W:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Starts at a negedge with the new operands; returns at the negedge where
    // done is expected high. intrude=1 raises start mid-run with other operands.
    task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit intrude, input string tag);
        logic [W:0] e;
        e      = ref_sum(a, b);
        opnd_x = a;
        opnd_y = b;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R2 busy"}, 32'(busy), 32'd1);
        check({tag, " R2 carry clear"}, 32'(carry_out), 32'd0);
        check({tag, " R2 done low"}, 32'(done), 32'd0);
        for (int k = 1; k < W; k++) begin
            if (intrude && k == 2) begin
                opnd_x = ~a;
                opnd_y = a ^ 8'h5A;
                start  = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            if (k == 1) check({tag, " R9 first sum bit"}, 32'(sum_out[W-1]), 32'(a[0] ^ b[0]));
            check({tag, " R3 busy mid"}, 32'(busy), 32'd1);
            check({tag, " R3 no early done"}, 32'(done), 32'd0);
        end
        @(negedge clk);
        check({tag, " R3 busy fell"}, 32'(busy), 32'd0);
        check({tag, " R3 done"}, 32'(done), 32'd1);
        check({tag, intrude ? " R6 sum" : " R4 sum"}, 32'(sum_out), 32'(e[W-1:0]));
        check({tag, " R4 carry"}, 32'(carry_out), 32'(e[W]));
    endtask

    task automatic idle_hold(input int n);
        logic [W-1:0] s;
        logic         c;
        s = sum_out;
        c = carry_out;
        @(negedge clk);
        check("R3 done one cycle", 32'(done), 32'd0);
        opnd_x = 8'hC3;
        opnd_y = 8'h3C;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R7 sum hold", 32'(sum_out), 32'(s));
            check("R7 carry hold", 32'(carry_out), 32'(c));
            check("R7 stays idle", 32'(busy), 32'd0);
        end
    endtask

    initial begin : wd
        while (cyc < 150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [W-1:0] ra, rb;
        void'($urandom(32'h5EED_0042));
        rst    = 1'b1;
        start  = 1'b0;
        opnd_x = '0;
        opnd_y = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sum", 32'(sum_out), 32'd0);
        check("R1 carry", 32'(carry_out), 32'd0);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);

        do_op(8'h00, 8'h00, 0, "zero");
        idle_hold(3);
        do_op(8'hFF, 8'h01, 0, "wrap");
        idle_hold(2);
        do_op(8'h00, 8'h00, 0, "R5 after carry");
        idle_hold(1);
        do_op(8'hFF, 8'hFF, 0, "max");
        idle_hold(1);
        do_op(8'hA5, 8'h5A, 1, "R6 intrude");
        idle_hold(2);
        do_op(8'h81, 8'h7F, 1, "R6 intrude carry");
        // back-to-back: start while done is high
        do_op(8'h0F, 8'hF1, 0, "R8 chain1");
        do_op(8'h12, 8'h34, 0, "R8 chain2");
        do_op(8'hFF, 8'h80, 0, "R8 chain3");
        do_op(8'h01, 8'h02, 0, "R8 R5 chain4");
        idle_hold(2);

        for (int t = 0; t < 40; t++) begin
            ra = W'($urandom);
            rb = W'($urandom);
            do_op(ra, rb, (t % 5) == 3, "rand");
            if ((t % 3) != 0) idle_hold(1 + t % 3);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule